// File: doc/BRIEF.md
# Static Branch Predictor with Link-Register Fast Path

This unit sits in the fetch stage of a two-stage pipeline. It classifies each pre-decoded instruction as a conditional branch, a direct jump or an indirect jump. It then decides whether the fetch stage should redirect, and it hands the next-PC adder its two operands. Backward conditional branches are predicted taken. Direct and indirect jumps are always taken.

The base of an indirect jump is worked out before the execute stage sees the instruction. When the base register is x0, the base is zero. When it is the link register x1, the value arrives on a dedicated bypass port. It may be used in the same cycle when no long-latency instruction is outstanding and the instruction in IR does not write x1; otherwise the unit raises its wait output. Any other base register, including x5, takes the slow path. The unit waits until the execute stage is empty, then claims the shared register-file read port for one cycle and uses the returned value in the next cycle. A small state machine tracks that claim with two states. In `ST_IDLE` no read is claimed. In `ST_CLAIMED` the read was issued in the previous cycle and its data is valid now. The machine has two transitions. The *claim* transition goes from ST_IDLE to ST_CLAIMED; it fires when a slow-path jump is present, the execute stage is empty and no flush is asserted. The *release* transition goes from ST_CLAIMED back to ST_IDLE and always fires after one cycle. Reset and flush both leave the machine in ST_IDLE.

While wait is high, the valid that fetch presents to execute is forced low. A misprediction flush drops any wait and any claim.

Top module: `bpu_static`

## Requirements
- R1: A jump-and-link (`dec_jal`) is predicted taken, with `add_op1` = `pc` and `add_op2` = `dec_imm`, and it never waits.
- R2: A conditional branch (`dec_bcond`) is predicted taken exactly when bit 31 of `dec_imm` is 1 (a negative offset). Its operands are `pc` and `dec_imm`.
- R3: An indirect jump (`dec_jalr`) with `dec_rs1_idx` = 0 is taken with `add_op1` = 0 and `add_op2` = `dec_imm`, and it never waits.
- R4: An indirect jump with `dec_rs1_idx` = 1 is taken with `add_op1` = `x1_val` and does not wait, provided `inflight_empty` is 1 and IR does not write x1. IR writes x1 when `ir_valid`, `ir_rd_wen` and `ir_rd_idx` = 1 all hold.
- R5: An indirect jump with `dec_rs1_idx` = 1 waits when `inflight_empty` is 0 or when IR writes x1. A write by IR to any other register, or an IR entry with `ir_rd_wen` = 0, does not cause a wait.
- R6: An indirect jump whose `dec_rs1_idx` is 2 or more waits without requesting a read while the execute stage is busy. The execute stage is busy when `inflight_empty` = 0 or `ir_valid` = 1.
- R7: Once the execute stage is empty, such a jump raises `rf_rd_req` with `rf_rd_idx` = `dec_rs1_idx` and waits in that cycle. In the next cycle it does not wait, it does not request, and `add_op1` = `rf_rs1_val`. This state lasts exactly one cycle.
- R8: x5 has no fast path. A jump through x5 behaves as in R6 and R7, whatever `x1_val` holds.
- R9: `fetch_valid_out` equals `fetch_valid_in` AND NOT `bpu_wait`.
- R10: While `flush` is 1, `bpu_wait` and `rf_rd_req` are 0 and no claim is recorded. A slow-path jump held through a flush issues its request again in the following cycle.
- R11: With `dec_valid` = 0, `pred_taken`, `bpu_wait` and `rf_rd_req` are 0, `add_op1` = `pc` and `add_op2` = `dec_imm`.
- R12: During reset and in the first cycle after it, no claim is recorded. A slow-path jump with the execute stage empty requests a read and waits.
- If more than one class flag is set, `dec_jalr` wins over `dec_jal`, and `dec_jal` wins over `dec_bcond`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Misprediction flush; clears wait and claim |
| dec_valid | input | 1 | A pre-decoded instruction is present |
| dec_bcond | input | 1 | Instruction is a conditional branch |
| dec_jal | input | 1 | Instruction is a direct jump |
| dec_jalr | input | 1 | Instruction is an indirect jump |
| dec_rs1_idx | input | 5 | Base register index of the indirect jump |
| dec_imm | input | 32 | Sign-extended offset |
| pc | input | 32 | Address of the instruction |
| inflight_empty | input | 1 | No long-latency instruction is outstanding |
| ir_valid | input | 1 | IR holds an instruction |
| ir_rd_wen | input | 1 | IR instruction writes a register |
| ir_rd_idx | input | 5 | Destination index of the IR instruction |
| x1_val | input | 32 | Link-register value from the bypass port |
| rf_rs1_val | input | 32 | Shared read-port data, one cycle after the request |
| fetch_valid_in | input | 1 | Fetch result ready for execute |
| pred_taken | output | 1 | Redirect predicted |
| add_op1 | output | 32 | Next-PC adder base |
| add_op2 | output | 32 | Next-PC adder offset |
| bpu_wait | output | 1 | Hold the fetch stage |
| rf_rd_req | output | 1 | Claim the shared read port this cycle |
| rf_rd_idx | output | 5 | Register index for the claimed read |
| fetch_valid_out | output | 1 | Gated valid toward execute |

## Verification
The hardest case to reach is the slow-path claim interacting with other events. A flush or a busy execute stage has to arrive in exactly the cycle the read port is claimed, or in the cycle the claimed data is consumed. The stimulus first holds an indirect jump through x5 or another register while toggling `ir_valid` and `inflight_empty`. It then asserts a flush in the claim cycle, so that the repeated request becomes visible. After that, a long run biases the base index toward 0, 1, 5 and other registers and keeps the same instruction for several cycles, so that claim and release chains happen often. A behavioural model tracks the claim and compares every output on every cycle.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_CLAIMED = 1'b1
    } claim_st_e;

    typedef enum logic [2:0] {
        CT_NONE      = 3'd0,
        CT_BCOND     = 3'd1,
        CT_JAL       = 3'd2,
        CT_JALR_ZERO = 3'd3,
        CT_JALR_LINK = 3'd4,
        CT_JALR_GPR  = 3'd5
    } ctl_class_e;
endpackage

// File: rtl/bpu_classify.sv
module bpu_classify
    import bpu_pkg::*;
#(
    parameter int REGIDX_W = 5,
    parameter int LINK_IDX = 1
) (
    input  logic                dec_valid,
    input  logic                dec_bcond,
    input  logic                dec_jal,
    input  logic                dec_jalr,
    input  logic [REGIDX_W-1:0] dec_rs1_idx,
    input  logic                inflight_empty,
    input  logic                ir_valid,
    input  logic                ir_rd_wen,
    input  logic [REGIDX_W-1:0] ir_rd_idx,
    output ctl_class_e          cls,
    output logic                link_hazard,
    output logic                exu_idle
);
    localparam logic [REGIDX_W-1:0] ZERO_REG = '0;
    localparam logic [REGIDX_W-1:0] LINK_REG = REGIDX_W'(LINK_IDX);

    logic ir_writes_link;

    always_comb begin
        ir_writes_link = ir_valid && ir_rd_wen && (ir_rd_idx == LINK_REG);
        link_hazard    = !inflight_empty || ir_writes_link;
        exu_idle       = inflight_empty && !ir_valid;
    end

    always_comb begin
        cls = CT_NONE;
        if (dec_valid) begin
            if (dec_jalr) begin
                if (dec_rs1_idx == ZERO_REG)      cls = CT_JALR_ZERO;
                else if (dec_rs1_idx == LINK_REG) cls = CT_JALR_LINK;
                else                              cls = CT_JALR_GPR;
            end else if (dec_jal) begin
                cls = CT_JAL;
            end else if (dec_bcond) begin
                cls = CT_BCOND;
            end
        end
    end
endmodule

// File: rtl/bpu_claim_fsm.sv
module bpu_claim_fsm
    import bpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic gpr_jump,
    input  logic exu_idle,
    output logic claimed,
    output logic rd_req,
    output logic gpr_wait
);
    claim_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d     = ST_IDLE;
        rd_req   = 1'b0;
        gpr_wait = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                gpr_wait = gpr_jump && !flush;
                if (gpr_jump && exu_idle && !flush) begin
                    rd_req = 1'b1;
                    st_d   = ST_CLAIMED;
                end
            end
            ST_CLAIMED: begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign claimed = (st_q == ST_CLAIMED);

    // R7: the read port is claimed for one cycle only
    p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R7: the cycle after a claim consumes the data without waiting
    p_claim_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (claimed && !gpr_wait));
    // R10: a flush never leaves a claim behind
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !claimed);
endmodule

// File: rtl/bpu_operands.sv
module bpu_operands
    import bpu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ctl_class_e      cls,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] x1_val,
    input  logic [XLEN-1:0] rf_val,
    output logic            taken,
    output logic [XLEN-1:0] op1,
    output logic [XLEN-1:0] op2
);
    localparam int SIGN_BIT = XLEN - 1;

    always_comb begin
        taken = 1'b0;
        op1   = pc;
        op2   = imm;
        unique case (cls)
            CT_NONE:      taken = 1'b0;
            CT_BCOND:     taken = imm[SIGN_BIT];
            CT_JAL:       taken = 1'b1;
            CT_JALR_ZERO: begin taken = 1'b1; op1 = '0;     end
            CT_JALR_LINK: begin taken = 1'b1; op1 = x1_val; end
            CT_JALR_GPR:  begin taken = 1'b1; op1 = rf_val; end
            default:      taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/bpu_static.sv
module bpu_static
    import bpu_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REGIDX_W = 5,
    parameter int LINK_IDX = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                dec_valid,
    input  logic                dec_bcond,
    input  logic                dec_jal,
    input  logic                dec_jalr,
    input  logic [REGIDX_W-1:0] dec_rs1_idx,
    input  logic [XLEN-1:0]     dec_imm,
    input  logic [XLEN-1:0]     pc,
    input  logic                inflight_empty,
    input  logic                ir_valid,
    input  logic                ir_rd_wen,
    input  logic [REGIDX_W-1:0] ir_rd_idx,
    input  logic [XLEN-1:0]     x1_val,
    input  logic [XLEN-1:0]     rf_rs1_val,
    input  logic                fetch_valid_in,
    output logic                pred_taken,
    output logic [XLEN-1:0]     add_op1,
    output logic [XLEN-1:0]     add_op2,
    output logic                bpu_wait,
    output logic                rf_rd_req,
    output logic [REGIDX_W-1:0] rf_rd_idx,
    output logic                fetch_valid_out
);
    ctl_class_e cls;
    logic       link_hazard, exu_idle;
    logic       claimed, gpr_wait, link_wait;

    bpu_classify #(.REGIDX_W(REGIDX_W), .LINK_IDX(LINK_IDX)) u_cls (
        .dec_valid      (dec_valid),
        .dec_bcond      (dec_bcond),
        .dec_jal        (dec_jal),
        .dec_jalr       (dec_jalr),
        .dec_rs1_idx    (dec_rs1_idx),
        .inflight_empty (inflight_empty),
        .ir_valid       (ir_valid),
        .ir_rd_wen      (ir_rd_wen),
        .ir_rd_idx      (ir_rd_idx),
        .cls            (cls),
        .link_hazard    (link_hazard),
        .exu_idle       (exu_idle)
    );

    bpu_claim_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .gpr_jump (cls == CT_JALR_GPR),
        .exu_idle (exu_idle),
        .claimed  (claimed),
        .rd_req   (rf_rd_req),
        .gpr_wait (gpr_wait)
    );

    bpu_operands #(.XLEN(XLEN)) u_ops (
        .cls    (cls),
        .pc     (pc),
        .imm    (dec_imm),
        .x1_val (x1_val),
        .rf_val (rf_rs1_val),
        .taken  (pred_taken),
        .op1    (add_op1),
        .op2    (add_op2)
    );

    always_comb begin
        link_wait       = (cls == CT_JALR_LINK) && link_hazard && !flush;
        bpu_wait        = link_wait || gpr_wait;
        rf_rd_idx       = dec_rs1_idx;
        fetch_valid_out = fetch_valid_in && !bpu_wait;
    end

    // R1: direct jumps redirect from the PC
    p_jal_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_jal && !dec_jalr) |-> (pred_taken && add_op1 == pc && !bpu_wait));
    // R4: clean link register is used at once
    p_link_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_jalr && dec_rs1_idx == REGIDX_W'(LINK_IDX) && inflight_empty
         && !(ir_valid && ir_rd_wen && ir_rd_idx == REGIDX_W'(LINK_IDX)))
        |-> (!bpu_wait && add_op1 == x1_val));
    // R5: outstanding work holds a link-register jump
    p_link_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_jalr && dec_rs1_idx == REGIDX_W'(LINK_IDX) && !inflight_empty && !flush)
        |-> bpu_wait);
    // R9: a waiting fetch never presents valid
    p_valid_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bpu_wait |-> !fetch_valid_out);
    // R6: busy execute stage never sees a read claim
    p_busy_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inflight_empty || ir_valid) |-> !rf_rd_req);
endmodule

// File: tb/sim_bpu_static.sv
`timescale 1ns/1ps
module sim_bpu_static;
    logic        clk = 0, rst_n = 0, flush = 0;
    logic        dec_valid = 0, dec_bcond = 0, dec_jal = 0, dec_jalr = 0;
    logic [4:0]  dec_rs1_idx = 0, ir_rd_idx = 0, rf_rd_idx;
    logic [31:0] dec_imm = 0, pc = 0, x1_val = 0, rf_rs1_val = 0;
    logic        inflight_empty = 1, ir_valid = 0, ir_rd_wen = 0, fetch_valid_in = 0;
    logic        pred_taken, bpu_wait, rf_rd_req, fetch_valid_out;
    logic [31:0] add_op1, add_op2;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit m_claimed = 0;

    always #2.5 clk = ~clk;

    bpu_static u0 (.*);

    function automatic bit claim_now();
        return rst_n ? 1'b0 : 1'b0;
    endfunction

    // Behavioural reference: expected outputs from current inputs and model claim bit
    bit e_taken, e_wait, e_req; logic [31:0] e_op1, e_op2; string tag;
    always_comb begin
        bit busy, x1dep;
        busy  = !inflight_empty || ir_valid;
        x1dep = !inflight_empty || (ir_valid && ir_rd_wen && ir_rd_idx == 5'd1);
        e_taken = 0; e_wait = 0; e_req = 0; e_op1 = pc; e_op2 = dec_imm; tag = "R11";
        if (dec_valid) begin
            if (dec_jalr) begin
                e_taken = 1;
                if (dec_rs1_idx == 0) begin e_op1 = 0; tag = "R3"; end
                else if (dec_rs1_idx == 1) begin
                    e_op1 = x1_val; e_wait = x1dep; tag = x1dep ? "R5" : "R4";
                end else begin
                    e_op1 = rf_rs1_val;
                    if (!m_claimed) begin e_wait = 1; e_req = !busy; end
                    tag = (dec_rs1_idx == 5) ? "R8" : ((busy && !m_claimed) ? "R6" : "R7");
                end
            end else if (dec_jal) begin e_taken = 1; tag = "R1"; end
            else if (dec_bcond) begin e_taken = dec_imm[31]; tag = "R2"; end
        end
        if (flush) begin e_wait = 0; e_req = 0; tag = "R10"; end
        if (!rst_n) tag = "R12";
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_claimed <= 0;
        else        m_claimed <= e_req;
    end

    task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", t, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        chk(tag, "pred_taken", 32'(pred_taken), 32'(e_taken));
        chk(tag, "bpu_wait",   32'(bpu_wait),   32'(e_wait));
        chk(tag, "rf_rd_req",  32'(rf_rd_req),  32'(e_req));
        chk(tag, "add_op1",    add_op1, e_op1);
        chk(tag, "add_op2",    add_op2, e_op2);
        if (e_req) chk("R7", "rf_rd_idx", 32'(rf_rd_idx), 32'(dec_rs1_idx));
        chk("R9", "fetch_valid_out", 32'(fetch_valid_out), 32'(fetch_valid_in && !e_wait));
        if (cyc > 200000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic put(input bit v, input bit bc, input bit j, input bit jr, input int rs1,
                       input logic [31:0] imm, input bit ie, input bit irv, input bit irw,
                       input int ird, input bit fl);
        dec_valid = v; dec_bcond = bc; dec_jal = j; dec_jalr = jr; dec_rs1_idx = 5'(rs1);
        dec_imm = imm; inflight_empty = ie; ir_valid = irv; ir_rd_wen = irw;
        ir_rd_idx = 5'(ird); flush = fl;
        pc = $urandom; x1_val = $urandom; rf_rs1_val = $urandom; fetch_valid_in = 1;
        @(posedge clk); #1;
    endtask

    initial begin
        #1;
        // R12: slow-path jump during reset requests with empty execute stage
        put(1,0,0,1,7,32'h10,1,0,0,0,0);
        put(1,0,0,1,7,32'h10,1,0,0,0,0);
        rst_n = 1;
        put(1,0,0,1,7,32'h10,1,0,0,0,0);   // first cycle after reset: claim
        put(1,0,0,1,7,32'h10,1,0,0,0,0);   // claimed data consumed
        // R1, R2
        put(1,0,1,0,0,32'h0000_0100,1,0,0,0,0);
        put(1,0,1,0,0,32'hFFFF_FF00,1,0,0,0,0);
        put(1,1,0,0,0,32'hFFFF_FFF8,1,0,0,0,0);
        put(1,1,0,0,0,32'h0000_0008,1,0,0,0,0);
        // R3
        put(1,0,0,1,0,32'h40,0,1,1,0,0);
        // R4 / R5
        put(1,0,0,1,1,32'h4,1,0,0,0,0);
        put(1,0,0,1,1,32'h4,0,0,0,0,0);
        put(1,0,0,1,1,32'h4,1,1,1,1,0);
        put(1,0,0,1,1,32'h4,1,1,1,2,0);
        put(1,0,0,1,1,32'h4,1,1,0,1,0);
        // R6 then R7 on a general register
        put(1,0,0,1,9,32'h20,0,0,0,0,0);
        put(1,0,0,1,9,32'h20,1,1,1,3,0);
        put(1,0,0,1,9,32'h20,1,0,0,0,0);
        put(1,0,0,1,9,32'h20,1,1,1,3,0);
        // R8: x5 takes the slow path
        put(1,0,0,1,5,32'h0,1,0,0,0,0);
        put(1,0,0,1,5,32'h0,1,0,0,0,0);
        // R10: flush in the claim cycle, request repeats next cycle
        put(1,0,0,1,6,32'h8,1,0,0,0,1);
        put(1,0,0,1,6,32'h8,1,0,0,0,0);
        put(1,0,0,1,6,32'h8,1,0,0,0,1);
        put(1,0,0,1,1,32'h8,0,0,0,0,1);
        // R11
        put(0,1,1,1,9,32'h8000_0000,1,0,0,0,0);
        // random run with held instructions
        for (int i = 0; i < 1500; i++) begin
            int sel = $urandom_range(0, 7);
            int rs  = (sel < 2) ? 0 : (sel < 4) ? 1 : (sel < 5) ? 5 : $urandom_range(2, 31);
            int hold = $urandom_range(1, 4);
            bit v = ($urandom_range(0, 7) != 0);
            bit bc = $urandom_range(0, 1), j = $urandom_range(0, 1), jr = $urandom_range(0, 1);
            logic [31:0] imm = $urandom;
            for (int k = 0; k < hold; k++)
                put(v, bc, j, jr, rs, imm, $urandom_range(0, 2) != 0, $urandom_range(0, 2) == 0,
                    $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 15) == 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule